// File: doc/BRIEF.md
# Packed Lane-Parallel Modular Adder/Subtractor

This block works on words that hold several small residues modulo a fixed modulus `P` side by side. Each residue sits in its own fixed-width field. The field is one bit wider than a residue needs, and that spare top bit is a guard bit. One pass adds or subtracts two such packed words in every lane at once. The core of the datapath is plain word-wide addition and subtraction. Mask arithmetic then finds the lanes that need a correction by `P`, and the correction is applied only to those lanes. No carry or borrow can cross from one lane into the next.

A caller presents two packed operands, an operation select and a valid strobe. One clock later the block returns the packed result and a valid flag. The word width `W` may be 32 or 64, and the modulus `P` is a parameter of at least 2. The field width and the lane count are derived from these two parameters.

Top module: `swar_modarith`

## Requirements
- R1: The field width is F = ceil(log2 P) + 1 and the lane count is K = floor(W / F). Lane i occupies bits [F*i + F-1 : F*i] and holds its residue in the low F-1 bits. Bit F*i + F-1 is the lane's guard bit.
- R2: With `op_sub` = 0, each output lane equals (a_i + b_i) mod P.
- R3: With `op_sub` = 1, each output lane equals (a_i - b_i) mod P. P is added back only in lanes where a_i < b_i.
- R4: A lane's result depends only on that lane's operands. This holds at the extremes: P-1 + P-1 in every lane, and 0 - (P-1) next to lanes that do not wrap.
- R5: When every operand lane lies in 0..P-1, every output lane lies in 0..P-1 and every guard bit of the output is 0.
- R6: Output bits at and above position K*F are always 0. Operand bits in that region have no effect on the result.
- R7: `out_valid` is high in exactly the cycles after a rising clock edge at which `in_valid` was high. The latency is one cycle.
- R8: While `in_valid` is low, `out_word` keeps its last value.
- R9: While `rst_n` is low, `out_valid` and `out_word` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_sub | input | 1 | 0 = lane-wise add, 1 = lane-wise subtract |
| opnd_a | input | W | First packed operand |
| opnd_b | input | W | Second packed operand |
| out_valid | output | 1 | Result word is valid |
| out_word | output | W | Packed reduced result |

## Verification
The reference-value and range assertions assume that every lane of both operands holds a residue below P. A lane value of P or more, or a set guard bit, breaks the no-spill argument. These assertions are gated on an in-range flag computed from the operands, so they only claim anything about legal input words. The stimulus builds every lane with a modulo-P expression, which keeps it legal. The only operand bits deliberately set outside that rule are the unused bits above the top lane, and the in-range flag does not look at those bits.

// File: rtl/swar_modarith_pkg.sv
package swar_modarith_pkg;

    // Field width: residue bits plus one guard bit.
    function automatic int fld_w(input int p);
        return $clog2(p) + 1;
    endfunction

    // Number of whole fields that fit into a word.
    function automatic int lane_cnt(input int w, input int p);
        return w / fld_w(p);
    endfunction

endpackage

// File: rtl/swar_field_masks.sv
module swar_field_masks
    import swar_modarith_pkg::*;
#(
    parameter int W = 32,
    parameter int P = 13
) (
    output logic [W-1:0] used_m,
    output logic [W-1:0] guard_m,
    output logic [W-1:0] pconst_m,
    output logic [W-1:0] cplus_m,
    output logic [W-1:0] even_m,
    output logic [W-1:0] odd_m,
    output logic [W:0]   ce_m,
    output logic [W:0]   co_m
);
    localparam int F = fld_w(P);
    localparam int K = lane_cnt(W, P);
    localparam logic [F-1:0] PL  = F'(P);
    localparam logic [F-1:0] CPL = F'((1 << F) - P);
    localparam logic [F-1:0] ONES = '1;

    always_comb begin
        used_m   = '0;
        guard_m  = '0;
        pconst_m = '0;
        cplus_m  = '0;
        even_m   = '0;
        odd_m    = '0;
        ce_m     = '0;
        co_m     = '0;
        for (int i = 0; i < K; i++) begin
            used_m[F*i +: F]   = ONES;
            guard_m[F*i + F-1] = 1'b1;
            pconst_m[F*i +: F] = PL;
            cplus_m[F*i +: F]  = CPL;
            if (i % 2 == 0) begin
                even_m[F*i +: F] = ONES;
                ce_m[F*(i+1)]    = 1'b1;
            end else begin
                odd_m[F*i +: F]  = ONES;
                co_m[F*(i+1)]    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/swar_add_path.sv
module swar_add_path #(
    parameter int W = 32,
    parameter int F = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] pconst_m,
    input  logic [W-1:0] cplus_m,
    input  logic [W-1:0] even_m,
    input  logic [W-1:0] odd_m,
    input  logic [W:0]   ce_m,
    input  logic [W:0]   co_m,
    output logic [W-1:0] res
);
    logic [W-1:0] raw;
    logic [W:0]   y_even;
    logic [W:0]   y_odd;
    logic [W:0]   carry_w;
    logic [W-1:0] ge_lsb;
    logic [W-1:0] ge_fld;

    always_comb begin
        // Lane sums stay below 2^F, so the word-wide add never spills.
        raw = a + b;
        // Add (2^F - P) in alternate lanes; a carry out of a lane means sum >= P.
        // The neighbouring lane is zero in both operands and absorbs the carry.
        y_even  = {1'b0, raw & even_m} + {1'b0, cplus_m & even_m};
        y_odd   = {1'b0, raw & odd_m}  + {1'b0, cplus_m & odd_m};
        carry_w = (y_even & ce_m) | (y_odd & co_m);
        // Move each carry to its own lane's LSB and spread it over the field.
        ge_lsb  = W'(carry_w >> F);
        ge_fld  = (ge_lsb << F) - ge_lsb;
        res     = raw - (pconst_m & ge_fld);
    end
endmodule

// File: rtl/swar_sub_path.sv
module swar_sub_path #(
    parameter int W = 32,
    parameter int F = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] guard_m,
    input  logic [W-1:0] pconst_m,
    output logic [W-1:0] res
);
    logic [W-1:0] diff;
    logic [W-1:0] bor_lsb;
    logic [W-1:0] bor_fld;

    always_comb begin
        // Preset each guard bit; the borrow of a lane is taken from its guard.
        diff    = (a | guard_m) - b;
        bor_lsb = (~diff & guard_m) >> (F - 1);
        bor_fld = (bor_lsb << F) - bor_lsb;
        // Add P back only where a lane borrowed, then drop the guard bits.
        res     = (diff + (pconst_m & bor_fld)) & ~guard_m;
    end
endmodule

// File: rtl/swar_modarith.sv
module swar_modarith
    import swar_modarith_pkg::*;
#(
    parameter int W = 32,
    parameter int P = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         op_sub,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic         out_valid,
    output logic [W-1:0] out_word
);
    localparam int F = fld_w(P);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] word;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0] used_m, guard_m, pconst_m, cplus_m, even_m, odd_m;
    logic [W:0]   ce_m, co_m;
    logic [W-1:0] a_m, b_m, sum_r, dif_r;

    swar_field_masks #(.W(W), .P(P)) u_masks (
        .used_m   (used_m),
        .guard_m  (guard_m),
        .pconst_m (pconst_m),
        .cplus_m  (cplus_m),
        .even_m   (even_m),
        .odd_m    (odd_m),
        .ce_m     (ce_m),
        .co_m     (co_m)
    );

    assign a_m = opnd_a & used_m;
    assign b_m = opnd_b & used_m;

    swar_add_path #(.W(W), .F(F)) u_add (
        .a        (a_m),
        .b        (b_m),
        .pconst_m (pconst_m),
        .cplus_m  (cplus_m),
        .even_m   (even_m),
        .odd_m    (odd_m),
        .ce_m     (ce_m),
        .co_m     (co_m),
        .res      (sum_r)
    );

    swar_sub_path #(.W(W), .F(F)) u_sub (
        .a        (a_m),
        .b        (b_m),
        .guard_m  (guard_m),
        .pconst_m (pconst_m),
        .res      (dif_r)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.word = (op_sub ? dif_r : sum_r) & used_m;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign out_word  = state_q.word;
endmodule

// File: rtl/swar_modarith_checker.sv
module swar_modarith_checker
    import swar_modarith_pkg::*;
#(
    parameter int W = 32,
    parameter int P = 13
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         op_sub,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         out_valid,
    input logic [W-1:0] out_word
);
    localparam int F = fld_w(P);
    localparam int K = lane_cnt(W, P);
    localparam logic [W-1:0] LMASK = W'((1 << F) - 1);

    logic         in_ok;
    logic         out_ok;
    logic [W-1:0] ref_word;

    always_comb begin
        int ua, ub, uo, r;
        in_ok    = 1'b1;
        out_ok   = 1'b1;
        ref_word = '0;
        for (int i = 0; i < K; i++) begin
            ua = int'((opnd_a >> (F*i)) & LMASK);
            ub = int'((opnd_b >> (F*i)) & LMASK);
            uo = int'((out_word >> (F*i)) & LMASK);
            if (ua >= P || ub >= P) in_ok = 1'b0;
            if (uo >= P) out_ok = 1'b0;
            r = op_sub ? (ua + P - ub) % P : (ua + ub) % P;
            ref_word[F*i +: F] = F'(r);
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word)); // R8
    AST_ADD_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sub && in_ok) |=> (out_word == $past(ref_word))); // R2
    AST_SUB_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sub && in_ok) |=> (out_word == $past(ref_word))); // R3
    AST_LANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ok) |=> out_ok); // R5

    generate
        if (K * F < W) begin : g_upper
            AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (out_word >> (K*F)) == '0); // R6
        end
    endgenerate
endmodule

bind swar_modarith swar_modarith_checker #(.W(W), .P(P)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sub    (op_sub),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/swar_modarith_bench.sv
module swar_modarith_bench;
    localparam int W = 32;
    localparam int P = 13;
    localparam int F = $clog2(P) + 1;
    localparam int K = W / F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_sub = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         out_valid;
    logic [W-1:0] out_word;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    swar_modarith #(.W(W), .P(P)) u_swar_modarith (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sub    (op_sub),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lane i = (base + i*step) mod P (R1 layout)
    function automatic logic [W-1:0] mk(input int base, input int step);
        logic [W-1:0] w = '0;
        for (int i = 0; i < K; i++) w[F*i +: F] = F'((base + i*step) % P);
        return w;
    endfunction

    function automatic logic [W-1:0] expect_of(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub);
        logic [W-1:0] w = '0;
        for (int i = 0; i < K; i++) begin
            int x = int'(a[F*i +: F]);
            int y = int'(b[F*i +: F]);
            w[F*i +: F] = F'(sub ? (x - y + P) % P : (x + y) % P);
        end
        return w;
    endfunction

    function automatic bit lanes_ok(input logic [W-1:0] w);
        for (int i = 0; i < K; i++) if (int'(w[F*i +: F]) >= P) return 1'b0;
        return 1'b1;
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub,
                         input logic [W-1:0] exp, input string req);
        opnd_a = a; opnd_b = b; op_sub = sub; in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b1, "R7 valid after one cycle", {31'd0, out_valid}, 1);
        chk(out_word == exp, req, out_word, exp);
    endtask

    initial begin
        logic [W-1:0] a, b, e, held, top_a;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 reset valid", {31'd0, out_valid}, 0);
        chk(out_word == '0, "R9 reset word", out_word, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Lane-pattern sweep over every base pair and both operations
        for (int x = 0; x < P; x++) begin
            for (int y = 0; y < P; y++) begin
                for (int s = 0; s < 2; s++) begin
                    a = mk(x, 1);
                    b = mk(y, 5);
                    e = expect_of(a, b, s[0]);
                    apply(a, b, s[0], e, s[0] ? "R3 lane subtract" : "R2 lane add");
                    chk(lanes_ok(out_word), "R5 lanes below P", out_word, e);
                end
            end
        end

        // R4 extremes: every lane P-1 + P-1
        a = mk(P-1, 0);
        apply(a, a, 1'b0, mk(P-2, 0), "R4 max add in all lanes");
        // R4: wrapping lanes (0 - (P-1)) next to non-wrapping lanes
        a = '0; b = '0;
        for (int i = 0; i < K; i++) begin
            a[F*i +: F] = (i % 2 == 0) ? F'(0) : F'(P-1);
            b[F*i +: F] = (i % 2 == 0) ? F'(P-1) : F'(0);
        end
        apply(a, b, 1'b1, expect_of(a, b, 1'b1), "R4 alternating borrow");

        // R1: only the top lane active, then only lane 0
        a = '0; b = '0;
        a[F*(K-1) +: F] = F'(P-1); b[F*(K-1) +: F] = F'(1);
        apply(a, b, 1'b0, '0, "R1 top lane wraps to zero");
        a = '0; b = '0;
        a[F-1:0] = F'(3); b[F-1:0] = F'(5);
        e = '0; e[F-1:0] = F'((3 - 5 + P) % P);
        apply(a, b, 1'b1, e, "R1 lane zero subtract");

        // R6: junk above the top lane is ignored and cleared
        a = mk(7, 3); b = mk(9, 4);
        e = expect_of(a, b, 1'b0);
        top_a = a; if (K*F < W) top_a = a | ~((W'(1) << (K*F)) - W'(1));
        apply(top_a, top_a ^ a ^ b, 1'b0, e, "R6 upper bits ignored");
        chk((out_word >> (K*F)) == '0, "R6 upper bits zero", out_word, e);

        // R8 hold and R7 idle valid
        held = out_word;
        in_valid = 1'b0; opnd_a = mk(1, 2); opnd_b = mk(4, 1); op_sub = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 valid drops", {31'd0, out_valid}, 0);
        chk(out_word == held, "R8 hold word", out_word, held);
        @(negedge clk);
        chk(out_word == held, "R8 hold word second cycle", out_word, held);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule